// File: doc/BRIEF.md
# Poison-Bit Tracker with Head Pseudo-Retire

This block keeps one poison flag per architectural register while the core runs ahead of a long-latency miss. Each dispatch lane presents up to two source register numbers and one destination register number. The block reports whether that destination will hold a poisoned (meaningless) value and records the result in its flag table. Lanes in the same cycle are resolved oldest to youngest, so a younger lane sees the result of an older lane at once. The instruction whose miss started the speculative episode is flagged by the caller, and its destination is always poisoned.

At the oldest slot of the window, the block decides whether the instruction may leave. A poisoned instruction leaves at once without waiting to execute, which is called a pseudo-retire. A clean instruction leaves only once its execution has completed. When speculative mode ends, every flag is wiped, so normal execution starts from a clean table.

Top module: `poison_tracker`

## Requirements
- R1: A valid lane whose used source A or used source B names a poisoned register reports `dst_inv` high for that lane in the same cycle.
- R2: A valid lane reports `dst_inv` low when it is not the trigger and no used source is poisoned. This includes a lane with no used sources. A source whose use flag is low is ignored, whatever register it names.
- R3: A valid lane with `disp_trig` high reports `dst_inv` high, whatever its sources are.
- R4: While `spec_mode` is high, a valid lane with `disp_dst_use` high writes its `dst_inv` value into bit `disp_dst` of `inv_bits`, and this is visible after the next rising edge. A clean write clears a poisoned register. A lane with `disp_vld` low writes nothing and reports `dst_inv` low.
- R5: A younger lane (higher index) reading a register that an older lane writes in the same cycle uses the older lane's `dst_inv` result, not the stored flag.
- R6: When two lanes write the same register in one cycle, the younger lane's value is the one stored.
- R7: With `spec_mode` high, a valid head with `head_inv` high asserts both `head_retire` and `head_pseudo` in the same cycle, whether or not `head_done` is high.
- R8: A valid head with `head_inv` low asserts `head_retire` only when `head_done` is high, and never asserts `head_pseudo`. With `spec_mode` low, `head_inv` is ignored.
- R9: Whenever `spec_mode` is low at a rising edge, all bits of `inv_bits` are zero after that edge, and no lane write takes effect.
- R10: After reset, `inv_bits` is all zero.
- R11: With `head_vld` low, neither `head_retire` nor `head_pseudo` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| spec_mode | input | 1 | High while running ahead of a miss |
| disp_vld | input | LANES | Lane carries an instruction |
| disp_trig | input | LANES | Lane is the miss that started speculation |
| disp_a_use | input | LANES | Source A is read |
| disp_a | input | LANES x RW | Source A register |
| disp_b_use | input | LANES | Source B is read |
| disp_b | input | LANES x RW | Source B register |
| disp_dst_use | input | LANES | Lane writes a register |
| disp_dst | input | LANES x RW | Destination register |
| dst_inv | output | LANES | Destination poisoned, per lane |
| head_vld | input | 1 | Oldest window slot is occupied |
| head_inv | input | 1 | Oldest instruction is poisoned |
| head_done | input | 1 | Oldest instruction finished execution |
| head_retire | output | 1 | Oldest instruction leaves this cycle |
| head_pseudo | output | 1 | It leaves without executing |
| inv_bits | output | NREGS | Current poison flag per register |

## Verification
The lane logic is driven with the trigger alone, with poison on source A only, and with poison on source B only. These show that each source position and the trigger path poison the destination separately. Unused sources that name poisoned registers and no-source writers show that a use flag masks a source and that a clean write clears a flag. Two lanes are paired on a shared register, both as a read of an older lane's destination and as a double write. This separates same-cycle forwarding and younger-wins ordering from the stored state. The head is swept over its valid, poisoned and done combinations inside and outside speculative mode, which tells pseudo-retire apart from normal retire and from holding.

// File: rtl/poison_pkg.sv
package poison_pkg;

  typedef enum logic [1:0] {
    HA_WAIT   = 2'd0,
    HA_RETIRE = 2'd1,
    HA_PSEUDO = 2'd2
  } head_act_e;

  // Oldest-slot decision: poisoned entries leave at once while running ahead,
  // clean ones wait for completion.
  function automatic head_act_e head_decide(input logic vld, input logic inv,
                                            input logic done, input logic spec);
    if (!vld)         return HA_WAIT;
    if (spec && inv)  return HA_PSEUDO;
    if (done)         return HA_RETIRE;
    return HA_WAIT;
  endfunction

endpackage

// File: rtl/poison_lanes.sv
module poison_lanes #(
  parameter int LANES = 2,
  parameter int NREGS = 32,
  localparam int RW   = $clog2(NREGS)
) (
  input  logic [NREGS-1:0]           flags_q,
  input  logic [LANES-1:0]           vld,
  input  logic [LANES-1:0]           trig,
  input  logic [LANES-1:0]           a_use,
  input  logic [LANES-1:0][RW-1:0]   a_reg,
  input  logic [LANES-1:0]           b_use,
  input  logic [LANES-1:0][RW-1:0]   b_reg,
  input  logic [LANES-1:0]           d_use,
  input  logic [LANES-1:0][RW-1:0]   d_reg,
  output logic [LANES-1:0]           lane_inv,
  output logic [LANES-1:0]           lane_wr,
  output logic [NREGS-1:0]           flags_nxt
);

  function automatic logic src_poison(input logic [NREGS-1:0] view,
                                      input logic t,
                                      input logic ua, input logic [RW-1:0] ra,
                                      input logic ub, input logic [RW-1:0] rb);
    return t | (ua & view[ra]) | (ub & view[rb]);
  endfunction

  for (genvar k = 0; k < LANES; k++) begin : g_wr
    assign lane_wr[k] = vld[k] & d_use[k];
  end

  // Oldest to youngest: each lane reads the view left by the older lanes,
  // so forwarding and younger-wins both fall out of the same walk.
  always_comb begin
    logic [NREGS-1:0] view;
    logic [LANES-1:0] res;
    view = flags_q;
    res  = '0;
    for (int k = 0; k < LANES; k++) begin
      res[k] = vld[k] & src_poison(view, trig[k], a_use[k], a_reg[k],
                                   b_use[k], b_reg[k]);
      if (lane_wr[k]) view[d_reg[k]] = res[k];
    end
    lane_inv  = res;
    flags_nxt = view;
  end

endmodule

// File: rtl/poison_table.sv
module poison_table #(
  parameter int NREGS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spec,
  input  logic [NREGS-1:0] flags_nxt,
  output logic [NREGS-1:0] flags_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flags_q <= '0;
    else if (!spec) flags_q <= '0;
    else            flags_q <= flags_nxt;
  end

  // R9
  clear_on_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !spec |=> flags_q == '0);

endmodule

// File: rtl/poison_head.sv
module poison_head
  import poison_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic spec,
  input  logic vld,
  input  logic inv,
  input  logic done,
  output logic retire,
  output logic pseudo
);

  head_act_e act;

  always_comb begin
    act    = head_decide(vld, inv, done, spec);
    retire = (act == HA_RETIRE) || (act == HA_PSEUDO);
    pseudo = (act == HA_PSEUDO);
  end

  // R7
  pseudo_leaves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pseudo |-> retire && inv && spec);
  // R8
  clean_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !inv && !done) |-> !retire);
  // R11
  empty_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |-> !retire && !pseudo);

endmodule

// File: rtl/poison_tracker.sv
module poison_tracker #(
  parameter int LANES = 2,
  parameter int NREGS = 32,
  localparam int RW   = $clog2(NREGS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       spec_mode,
  input  logic [LANES-1:0]           disp_vld,
  input  logic [LANES-1:0]           disp_trig,
  input  logic [LANES-1:0]           disp_a_use,
  input  logic [LANES-1:0][RW-1:0]   disp_a,
  input  logic [LANES-1:0]           disp_b_use,
  input  logic [LANES-1:0][RW-1:0]   disp_b,
  input  logic [LANES-1:0]           disp_dst_use,
  input  logic [LANES-1:0][RW-1:0]   disp_dst,
  output logic [LANES-1:0]           dst_inv,
  input  logic                       head_vld,
  input  logic                       head_inv,
  input  logic                       head_done,
  output logic                       head_retire,
  output logic                       head_pseudo,
  output logic [NREGS-1:0]           inv_bits
);

  logic [LANES-1:0] lane_wr;
  logic [NREGS-1:0] flags_nxt;

  poison_lanes #(.LANES(LANES), .NREGS(NREGS)) u_lanes (
    .flags_q  (inv_bits),
    .vld      (disp_vld),
    .trig     (disp_trig),
    .a_use    (disp_a_use),
    .a_reg    (disp_a),
    .b_use    (disp_b_use),
    .b_reg    (disp_b),
    .d_use    (disp_dst_use),
    .d_reg    (disp_dst),
    .lane_inv (dst_inv),
    .lane_wr  (lane_wr),
    .flags_nxt(flags_nxt)
  );

  poison_table #(.NREGS(NREGS)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .spec     (spec_mode),
    .flags_nxt(flags_nxt),
    .flags_q  (inv_bits)
  );

  poison_head u_head (
    .clk   (clk),
    .rst_n (rst_n),
    .spec  (spec_mode),
    .vld   (head_vld),
    .inv   (head_inv),
    .done  (head_done),
    .retire(head_retire),
    .pseudo(head_pseudo)
  );

  // R3
  trigger_poisons_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_vld[0] && disp_trig[0]) |-> dst_inv[0]);
  // R2
  no_source_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_vld[0] && !disp_trig[0] && !disp_a_use[0] && !disp_b_use[0]) |-> !dst_inv[0]);
  // R4
  idle_lane_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_vld[0] |-> !dst_inv[0] && !lane_wr[0]);
  // R6
  younger_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spec_mode && lane_wr[LANES-1]) |=>
      inv_bits[$past(disp_dst[LANES-1])] == $past(dst_inv[LANES-1]));

endmodule

// File: tb/poison_tracker_test.sv
`timescale 1ns/1ps
module poison_tracker_test;

  localparam int L  = 2;
  localparam int NR = 32;
  localparam int RW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spec_mode;
  logic [L-1:0] disp_vld, disp_trig, disp_a_use, disp_b_use, disp_dst_use;
  logic [L-1:0][RW-1:0] disp_a, disp_b, disp_dst;
  logic [L-1:0] dst_inv;
  logic head_vld, head_inv, head_done, head_retire, head_pseudo;
  logic [NR-1:0] inv_bits;

  always #4 clk = ~clk;

  poison_tracker #(.LANES(L), .NREGS(NR)) uut (.*);

  typedef struct { string tag; int kind; logic [NR-1:0] exp; } item_t;
  item_t q[$];
  logic [NR-1:0] model = '0;
  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  task automatic idle();
    disp_vld = '0; disp_trig = '0; disp_a_use = '0; disp_b_use = '0;
    disp_dst_use = '0; disp_a = '0; disp_b = '0; disp_dst = '0;
    head_vld = 0; head_inv = 0; head_done = 0;
  endtask

  task automatic lane(int k, bit t, bit ua, int a, bit ub, int b, bit ud, int d);
    disp_vld[k] = 1'b1; disp_trig[k] = t;
    disp_a_use[k] = ua; disp_a[k] = RW'(a);
    disp_b_use[k] = ub; disp_b[k] = RW'(b);
    disp_dst_use[k] = ud; disp_dst[k] = RW'(d);
  endtask

  task automatic head(bit v, bit i, bit d);
    head_vld = v; head_inv = i; head_done = d;
  endtask

  // Driver: expected values from the requirements, pushed for this cycle.
  task automatic tick(string tag);
    logic [NR-1:0] seen;
    logic res;
    seen = model;
    q.push_back('{tag, 4, model});
    for (int k = 0; k < L; k++) begin
      res = 1'b0;
      if (disp_vld[k]) begin
        if (disp_trig[k]) res = 1'b1;
        if (disp_a_use[k] && seen[disp_a[k]]) res = 1'b1;
        if (disp_b_use[k] && seen[disp_b[k]]) res = 1'b1;
        if (disp_dst_use[k]) seen[disp_dst[k]] = res;
      end
      q.push_back('{tag, k, NR'(res)});
    end
    q.push_back('{tag, 2, NR'(head_vld && ((spec_mode && head_inv) || head_done))});
    q.push_back('{tag, 3, NR'(head_vld && spec_mode && head_inv)});
    model = spec_mode ? seen : '0;
    @(negedge clk);
    idle();
  endtask

  // Monitor: compares mid low phase, after the driver settled the inputs.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (q.size() > 0) begin
        item_t it;
        logic [NR-1:0] act;
        it = q.pop_front();
        case (it.kind)
          0: act = NR'(dst_inv[0]);
          1: act = NR'(dst_inv[1]);
          2: act = NR'(head_retire);
          3: act = NR'(head_pseudo);
          default: act = inv_bits;
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s kind %0d: actual %h expected %h", it.tag, it.kind, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    spec_mode = 1'b1;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick("R10 reset state");
    // trigger poisons r3
    lane(0, 1, 1, 1, 0, 0, 1, 3); tick("R3 trigger");
    // source A poisoned; lane1 unused A names r3, B clean
    lane(0, 0, 1, 3, 0, 0, 1, 5);
    lane(1, 0, 0, 3, 1, 7, 1, 6); tick("R1 src A / R2 masked source");
    // clean no-source write clears r3, lane1 sees forwarded r3 but B=r5 poisoned
    lane(0, 0, 0, 0, 0, 0, 1, 3);
    lane(1, 0, 1, 3, 1, 5, 1, 8); tick("R4 clear / R1 src B / R5");
    // forwarding of a poisoned older result
    lane(0, 1, 0, 0, 0, 0, 1, 10);
    lane(1, 0, 1, 10, 0, 0, 1, 11); tick("R5 forward poison");
    // forwarding of a clean older result over a poisoned stored flag
    lane(0, 0, 0, 0, 0, 0, 1, 8);
    lane(1, 0, 0, 0, 1, 8, 1, 14); tick("R5 forward clean");
    // double write: younger clean wins
    lane(0, 1, 0, 0, 0, 0, 1, 12);
    lane(1, 0, 0, 0, 0, 0, 1, 12); tick("R6 younger clean");
    // double write: younger poisoned wins
    lane(0, 0, 0, 0, 0, 0, 1, 13);
    lane(1, 0, 1, 5, 0, 0, 1, 13); tick("R6 younger poison");
    // invalid lane with trigger set
    disp_trig[0] = 1'b1; disp_dst_use[0] = 1'b1; disp_dst[0] = 5'd20;
    tick("R4 idle lane");
    tick("R4 idle lane no write");
    head(1, 1, 0); tick("R7 pseudo");
    head(1, 1, 1); tick("R7 pseudo with done");
    head(1, 0, 0); tick("R8 wait");
    head(1, 0, 1); tick("R8 retire");
    head(0, 1, 1); tick("R11 empty head");
    // leave speculative mode
    spec_mode = 1'b0;
    lane(0, 1, 0, 0, 0, 0, 1, 20);
    head(1, 1, 0); tick("R9 exit / R8 inv ignored");
    lane(0, 0, 1, 5, 0, 0, 1, 21); tick("R9 cleared");
    spec_mode = 1'b1;
    lane(0, 0, 1, 5, 1, 13, 1, 22); tick("R9 clean restart");
    lane(0, 1, 0, 0, 0, 0, 1, 31);
    lane(1, 0, 0, 0, 1, 31, 1, 0); tick("R1 R3 top registers");
    tick("R4 final state");
    repeat (2) @(negedge clk);
    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule